// File: doc/BRIEF.md
# Single-Cycle Insertion Sorter with Median Tap

This block holds up to `DEPTH` unsigned keys in ascending order in a row of registers, with slot 0 the smallest. A request can insert one key, delete one key, or do both at once. Every request finishes in a single clock cycle.

Each request compares the incoming key with every stored key in parallel, and compares the delete key the same way. This gives two thermometer masks. From them, each slot picks one of four actions:

- hold its value,
- take the value of the slot below,
- take the value of the slot above,
- load the incoming key.

A stored key therefore moves by at most one slot per cycle. The new key can land in any slot. No storage is used beyond the slots themselves.

The main use is a sliding-window median filter. Each cycle the oldest sample of the window is deleted and the newest is inserted. The middle entry is always available on a dedicated output.

Top module: `insort_array`

## Requirements
- R1: After reset:
  - every slot is empty (`sorted_valid` all zero),
  - `count` is 0 and `median` is 0,
  - `overflow` and `miss` are low.
- R2: An accepted insert becomes visible in the cycle after the request.
  - The occupied slots stay in ascending order from slot 0.
  - Slot `i` is bits `[i*WIDTH +: WIDTH]` of `sorted_data`.
- R3: An insert into a full array, with no successful delete in the same request, is dropped and the contents are unchanged. `overflow` is high for exactly the one cycle after the request.
- R4: A delete removes the lowest-numbered slot holding a key equal to `del_key`. Every slot above it moves down by one, and the top occupied slot becomes empty.
- R5: A delete whose key is not stored leaves the contents unchanged. `miss` is high for exactly the one cycle after the request.
- R6: An insert and a successful delete in the same request complete together in one cycle.
  - `count` does not change.
  - The order is correct, including when the array is full.
  - The order is correct whether the new key lands below or above the removed one.
- R7: `median` shows the key in slot `count/2` (integer division). It is 0 when the array is empty.
- R8: Occupancy rules:
  - `count` always equals the number of set bits in `sorted_valid`.
  - The occupied slots are always contiguous from slot 0.
  - Equal keys are all kept.
- R9: While `req_valid` is low, `req_ins` and `req_del` have no effect on the contents, `count` or the flags.
- R10: If a combined request's delete misses, the insert goes ahead on its own.
  - It is accepted if the array has room.
  - On a full array it is dropped, and `overflow` and `miss` both rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_valid | input | 1 | Qualifies `req_ins` and `req_del` for this cycle |
| req_ins | input | 1 | Insert `ins_data` |
| req_del | input | 1 | Delete one copy of `del_key` |
| ins_data | input | WIDTH | Key to insert |
| del_key | input | WIDTH | Key to delete |
| sorted_data | output | DEPTH*WIDTH | All slots, slot `i` at `[i*WIDTH +: WIDTH]`, ascending |
| sorted_valid | output | DEPTH | Occupancy bit per slot |
| count | output | $clog2(DEPTH+1) | Number of occupied slots |
| median | output | WIDTH | Key in slot `count/2`, or 0 when empty |
| overflow | output | 1 | One-cycle pulse when an insert is dropped |
| miss | output | 1 | One-cycle pulse when a delete key is not found |

## Verification
Insert and delete can fall in the same cycle. They interact through the shared per-slot select, so the bench drives `req_ins` and `req_del` together in several situations:

- on a full array, with the new key landing both below and above the removed slot;
- with the new key equal to the removed key;
- with a delete key that is absent, so the insert must run alone or be dropped.

Each result is judged against a bench-side model that applies the delete first and then the insert. The bench compares the whole ordered contents, the occupancy count and both flags in the cycle after the request.

// File: rtl/insort_pkg.sv
package insort_pkg;

  // Per-slot action selected each cycle.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,  // take the incoming key
    OP_UP   = 2'd2,  // take the value of the slot below (entries move upward)
    OP_DOWN = 2'd3   // take the value of the slot above (entries move downward)
  } slot_op_e;

endpackage

// File: rtl/sorter_match.sv
// Parallel compare of both request keys against every stored slot.
module sorter_match #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] slot_q,
  input  logic [DEPTH-1:0]            valid_q,
  input  logic [WIDTH-1:0]            ins_data,
  input  logic [WIDTH-1:0]            del_key,
  output logic [DEPTH-1:0]            above_mask,
  output logic [DEPTH-1:0]            del_mask,
  output logic                        del_found
);

  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    // Strictly greater keeps a new key above its equals.
    assign above_mask[i] = ~valid_q[i] | (slot_q[i] > ins_data);
    assign hit[i]        = valid_q[i] & (slot_q[i] == del_key);
    if (i == 0) begin : g_first
      assign del_mask[i] = hit[i];
    end else begin : g_rest
      assign del_mask[i] = del_mask[i-1] | hit[i];
    end
  end

  assign del_found = del_mask[DEPTH-1];

endmodule

// File: rtl/sorter_cell.sv
// One slot: key register plus occupancy bit, with a four-way next-value select.
module sorter_cell
  import insort_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_op_e         op,
  input  logic [WIDTH-1:0] ins_data,
  input  logic [WIDTH-1:0] below_data,
  input  logic             below_valid,
  input  logic [WIDTH-1:0] above_data,
  input  logic             above_valid,
  output logic [WIDTH-1:0] data_q,
  output logic             valid_q
);

  logic [WIDTH-1:0] data_d;
  logic             valid_d;
  logic             cell_en;

  always_comb begin
    data_d  = data_q;
    valid_d = valid_q;
    unique case (op)
      OP_LOAD: begin data_d = ins_data;   valid_d = 1'b1;        end
      OP_UP:   begin data_d = below_data; valid_d = below_valid; end
      OP_DOWN: begin data_d = above_data; valid_d = above_valid; end
      default: ;
    endcase
  end

  assign cell_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (cell_en) begin
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  // R2: a slot that loads the incoming key is occupied afterwards
  assert_load_sets_valid_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (valid_q && data_q == $past(ins_data))
  );

endmodule

// File: rtl/sorter_pick.sv
// Middle-entry selector: slot count/2 among the occupied slots.
module sorter_pick #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int CW    = 4
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] slot_q,
  input  logic [DEPTH-1:0]            valid_q,
  input  logic [CW-1:0]               count_q,
  output logic [WIDTH-1:0]            median
);

  logic [CW-1:0] mid_idx;

  assign mid_idx = count_q >> 1;

  always_comb begin
    median = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) == mid_idx && valid_q[i]) median = slot_q[i];
    end
  end

endmodule

// File: rtl/insort_array.sv
// Sorted register array with one-cycle insert, delete and combined update.
module insort_array
  import insort_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_ins,
  input  logic                   req_del,
  input  logic [WIDTH-1:0]       ins_data,
  input  logic [WIDTH-1:0]       del_key,
  output logic [DEPTH*WIDTH-1:0] sorted_data,
  output logic [DEPTH-1:0]       sorted_valid,
  output logic [CW-1:0]          count,
  output logic [WIDTH-1:0]       median,
  output logic                   overflow,
  output logic                   miss
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // Slot state
  logic [DEPTH-1:0][WIDTH-1:0] slot_q;
  logic [DEPTH-1:0]            valid_q;
  logic [CW-1:0]               count_q, count_d;
  logic                        ovf_q, ovf_d, miss_q, miss_d;

  // Compare masks
  logic [DEPTH-1:0] above_mask, del_mask_raw;
  logic             del_found;

  sorter_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match (
    .slot_q     (slot_q),
    .valid_q    (valid_q),
    .ins_data   (ins_data),
    .del_key    (del_key),
    .above_mask (above_mask),
    .del_mask   (del_mask_raw),
    .del_found  (del_found)
  );

  // Request qualification
  logic ins_req, del_req, ins_eff, del_eff, is_full;
  logic [DEPTH:0]   m_ext;
  logic [DEPTH-1:0] d_msk;

  assign is_full = (count_q == FULL_CNT);
  assign ins_req = req_valid & req_ins;
  assign del_req = req_valid & req_del;
  assign del_eff = del_req & del_found;
  assign ins_eff = ins_req & (~is_full | del_eff);
  assign m_ext   = {ins_eff, above_mask & {DEPTH{ins_eff}}};
  assign d_msk   = del_mask_raw & {DEPTH{del_eff}};

  // Per-slot select from the two thermometer masks
  slot_op_e [DEPTH-1:0] slot_op;
  logic     [DEPTH-1:0] load_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             m_lo, d_lo, ld, up, dn;
    logic [WIDTH-1:0] bel_d, abv_d;
    logic             bel_v, abv_v;

    if (i == 0) begin : g_bottom
      assign m_lo  = 1'b0;
      assign d_lo  = 1'b0;
      assign bel_d = '0;
      assign bel_v = 1'b0;
    end else begin : g_mid_lo
      assign m_lo  = m_ext[i-1];
      assign d_lo  = d_msk[i-1];
      assign bel_d = slot_q[i-1];
      assign bel_v = valid_q[i-1];
    end

    if (i == DEPTH - 1) begin : g_top
      assign abv_d = '0;
      assign abv_v = 1'b0;
    end else begin : g_mid_hi
      assign abv_d = slot_q[i+1];
      assign abv_v = valid_q[i+1];
    end

    // New key below or at the removed slot: load at the insert point.
    // New key above the removed slot: load one place lower.
    assign ld = (m_ext[i] & ~m_lo & ~d_lo) | (d_msk[i] & ~m_ext[i] & m_ext[i+1]);
    assign up = m_lo & ~d_lo;
    assign dn = d_msk[i] & ~m_ext[i+1];
    assign load_vec[i] = ld;

    always_comb begin
      if (ld)      slot_op[i] = OP_LOAD;
      else if (up) slot_op[i] = OP_UP;
      else if (dn) slot_op[i] = OP_DOWN;
      else         slot_op[i] = OP_HOLD;
    end

    sorter_cell #(.WIDTH(WIDTH)) u_cell (
      .clk         (clk),
      .rst_n       (rst_i),
      .op          (slot_op[i]),
      .ins_data    (ins_data),
      .below_data  (bel_d),
      .below_valid (bel_v),
      .above_data  (abv_d),
      .above_valid (abv_v),
      .data_q      (slot_q[i]),
      .valid_q     (valid_q[i])
    );

    // R2 / R8: occupied slots never fall out of ascending order
    if (i > 0) begin : g_order_chk
      assert_ascending_R2: assert property (
        @(posedge clk) disable iff (!rst_i)
        valid_q[i] |-> (valid_q[i-1] && slot_q[i] >= slot_q[i-1])
      );
    end
  end

  // Count and flags: next state
  always_comb begin
    count_d = count_q;
    unique case ({ins_eff, del_eff})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
    ovf_d  = ins_req & ~ins_eff;
    miss_d = del_req & ~del_found;
  end

  // Count and flags: registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
      miss_q  <= miss_d;
    end
  end

  sorter_pick #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_pick (
    .slot_q  (slot_q),
    .valid_q (valid_q),
    .count_q (count_q),
    .median  (median)
  );

  assign sorted_data  = slot_q;
  assign sorted_valid = valid_q;
  assign count        = count_q;
  assign overflow     = ovf_q;
  assign miss         = miss_q;

  // R8: registered count agrees with the occupancy bits
  assert_count_tracks_R8: assert property (
    @(posedge clk) disable iff (!rst_i)
    count_q == CW'($countones(valid_q))
  );

  // R2: at most one slot takes the incoming key per cycle
  assert_single_load_R2: assert property (
    @(posedge clk) disable iff (!rst_i)
    $onehot0(load_vec)
  );

  // R3: a dropped insert leaves occupancy unchanged
  assert_no_overflow_R3: assert property (
    @(posedge clk) disable iff (!rst_i)
    (ins_req && !ins_eff && !del_eff) |=> (ovf_q && $stable(valid_q) && $stable(slot_q))
  );

  // R5: a missed delete alone changes nothing
  assert_miss_unchanged_R5: assert property (
    @(posedge clk) disable iff (!rst_i)
    (del_req && !del_found && !ins_eff) |=> (miss_q && $stable(slot_q) && $stable(valid_q))
  );

  // R6: combined insert and delete keep the count
  assert_pair_keeps_count_R6: assert property (
    @(posedge clk) disable iff (!rst_i)
    (ins_eff && del_eff) |=> $stable(count_q)
  );

  // R9: idle request port changes nothing
  assert_idle_holds_R9: assert property (
    @(posedge clk) disable iff (!rst_i)
    !req_valid |=> ($stable(slot_q) && $stable(valid_q) && !ovf_q && !miss_q)
  );

endmodule

// File: tb/sim_insort_array.sv
module sim_insort_array;

  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 26;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   req_valid, req_ins, req_del;
  logic [WIDTH-1:0]       ins_data, del_key;
  logic [DEPTH*WIDTH-1:0] sorted_data;
  logic [DEPTH-1:0]       sorted_valid;
  logic [CW-1:0]          count;
  logic [WIDTH-1:0]       median;
  logic                   overflow, miss;

  always #4 clk = ~clk;  // 125 MHz

  insort_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ins(req_ins),
    .req_del(req_del), .ins_data(ins_data), .del_key(del_key),
    .sorted_data(sorted_data), .sorted_valid(sorted_valid), .count(count),
    .median(median), .overflow(overflow), .miss(miss)
  );

  int total = 0;
  int bad   = 0;

  // Reference model
  logic [WIDTH-1:0] mv[DEPTH];
  int  mc;
  bit  mo, mm;

  // Vector fields: {valid, ins, del, ins_data[7:0], del_key[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {3'b110, 8'd50,  8'd0},   {3'b110, 8'd20,  8'd0},   {3'b110, 8'd80,  8'd0},
    {3'b110, 8'd20,  8'd0},   {3'b110, 8'd5,   8'd0},   {3'b110, 8'd99,  8'd0},
    {3'b110, 8'd60,  8'd0},   {3'b110, 8'd70,  8'd0},   {3'b110, 8'd30,  8'd0},
    {3'b111, 8'd45,  8'd80},  {3'b101, 8'd0,   8'd20},  {3'b101, 8'd0,   8'd200},
    {3'b111, 8'd10,  8'd99},  {3'b111, 8'd100, 8'd5},   {3'b111, 8'd60,  8'd60},
    {3'b011, 8'd1,   8'd50},  {3'b111, 8'd255, 8'd10},  {3'b111, 8'd0,   8'd255},
    {3'b101, 8'd0,   8'd100}, {3'b101, 8'd0,   8'd0},   {3'b101, 8'd0,   8'd20},
    {3'b101, 8'd0,   8'd45},  {3'b101, 8'd0,   8'd60},  {3'b101, 8'd0,   8'd70},
    {3'b101, 8'd0,   8'd60},  {3'b101, 8'd0,   8'd60}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [DEPTH*WIDTH-1:0] act, input logic [DEPTH*WIDTH-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mv[i] = '0;
    mc = 0; mo = 0; mm = 0;
  endtask

  task automatic model_step(input bit v, input bit ins, input bit del,
                            input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] k);
    int  j;
    int  p;
    bit  full0, do_del, do_ins;
    mo = 0; mm = 0;
    if (!v) return;
    full0 = (mc == DEPTH);
    j = -1;
    for (int i = mc - 1; i >= 0; i--) if (mv[i] == k) j = i;
    do_del = del && (j >= 0);
    mm     = del && (j < 0);
    do_ins = ins && (!full0 || do_del);
    mo     = ins && !do_ins;
    if (do_del) begin
      for (int i = j; i < DEPTH - 1; i++) mv[i] = mv[i+1];
      mv[DEPTH-1] = '0;
      mc--;
    end
    if (do_ins) begin
      p = 0;
      for (int i = 0; i < mc; i++) if (mv[i] <= x) p++;
      for (int i = DEPTH - 1; i > p; i--) mv[i] = mv[i-1];
      mv[p] = x;
      mc++;
    end
  endtask

  task automatic compare_state(input string tag);
    logic [DEPTH*WIDTH-1:0] ef, mk;
    logic [DEPTH-1:0]       ev;
    logic [WIDTH-1:0]       emed;
    ef = '0; mk = '0; ev = '0;
    for (int i = 0; i < mc; i++) begin
      ef[i*WIDTH +: WIDTH] = mv[i];
      mk[i*WIDTH +: WIDTH] = '1;
      ev[i] = 1'b1;
    end
    emed = (mc == 0) ? '0 : mv[mc/2];
    chk(count == CW'(mc), {tag, " R8 count"}, count, mc);
    chk(sorted_valid == ev, {tag, " R8 valid"}, sorted_valid, ev);
    chk((sorted_data & mk) == ef, {tag, " R2 R4 R6 data"}, sorted_data & mk, ef);
    chk(overflow == mo, {tag, " R3 overflow"}, overflow, mo);
    chk(miss == mm, {tag, " R5 miss"}, miss, mm);
    chk(median == emed, {tag, " R7 median"}, median, emed);
  endtask

  task automatic drive(input bit v, input bit ins, input bit del,
                       input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] k);
    @(negedge clk);
    req_valid = v; req_ins = ins; req_del = del; ins_data = x; del_key = k;
    model_step(v, ins, del, x, k);
    @(negedge clk);
    req_valid = 1'b0; req_ins = 1'b0; req_del = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_ins = 1'b0; req_del = 1'b0;
    ins_data = '0; del_key = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(sorted_valid == '0, "R1 valid after reset", sorted_valid, 0);
    chk(count == '0, "R1 count after reset", count, 0);
    chk(median == '0, "R1 median after reset", median, 0);
    chk(!overflow && !miss, "R1 flags after reset", {overflow, miss}, 0);

    // Table walk: R2 R3 R4 R5 R6 R8 R9 R10 against the model
    for (int n = 0; n < NV; n++) begin
      drive(VEC[n][18], VEC[n][17], VEC[n][16], VEC[n][15:8], VEC[n][7:0]);
      compare_state($sformatf("vec%0d", n));
    end

    // R7: median picks slot count/2
    do_reset();
    drive(1, 1, 0, 8'd10, 0);
    drive(1, 1, 0, 8'd30, 0);
    drive(1, 1, 0, 8'd20, 0);
    chk(median == 8'd20, "R7 median of three", median, 20);
    drive(1, 1, 0, 8'd40, 0);
    chk(median == 8'd30, "R7 median of four", median, 30);

    // R9: idle port ignores ins/del strobes
    drive(0, 1, 1, 8'd5, 8'd10);
    chk(count == 4 && median == 8'd30 && !overflow && !miss,
        "R9 idle request ignored", {count, median}, {4'd4, 8'd30});
    compare_state("R9 idle");

    // R10: fill, then combined request with absent delete key
    for (int i = 0; i < 4; i++) drive(1, 1, 0, WIDTH'(50 + i), 0);
    drive(1, 1, 1, 8'd1, 8'd77);
    chk(overflow && miss, "R10 full pair with miss flags", {overflow, miss}, 2'b11);
    compare_state("R10 full miss");
    drive(1, 0, 1, 0, 8'd10);
    drive(1, 1, 1, 8'd2, 8'd77);
    chk(!overflow && miss && count == 8, "R10 room pair with miss inserts",
        {overflow, miss, count}, {2'b01, 4'd8});
    compare_state("R10 room miss");

    // R3: flag lasts one cycle
    drive(1, 1, 0, 8'd9, 0);
    chk(overflow, "R3 overflow raised", overflow, 1);
    @(negedge clk);
    chk(!overflow, "R3 overflow single cycle", overflow, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule